// File: doc/BRIEF.md
# Dynamic Delay Adjustment Controller

This block sits between user logic and the dynamic delay inputs of an on-chip clock synthesizer. User logic asks for a signed output-clock shift, counted in steps of 250 ps nominal. The block checks the request and turns it into the synthesizer's control word, which has a mode bit, a zero-delay flag, a lead/lag bit and a 3-bit magnitude code.

A delay change can make the synthesizer lose lock, so every accepted request starts a fixed sequence. First the new word is registered onto the outputs. Then the synthesizer reset is held for a parameterised number of cycles and released. Finally the block waits for the lock input before it reports completion by raising ready again. A parameterised watchdog limits that wait. If it expires, the block returns to idle with a sticky lock-fail flag. Requests are taken through a valid/ready handshake. A request that arrives while a sequence runs is stalled until ready returns, and is then taken as offered.

The sequencer has three states. `ST_IDLE` waits for a request. `ST_APPLY` holds the synthesizer reset while the counter runs. `ST_RELOCK` waits for lock with a watchdog count. The transitions are:
- *accept*: `ST_IDLE`→`ST_APPLY` on an in-range request.
- *reject*: `ST_IDLE`→`ST_IDLE` on an out-of-range request, which raises the error pulse.
- *hold_done*: `ST_APPLY`→`ST_RELOCK` when the reset count is complete.
- *locked*: `ST_RELOCK`→`ST_IDLE` when lock is sampled high.
- *timeout*: `ST_RELOCK`→`ST_IDLE` when the watchdog expires, which sets lock-fail.

Top module: `dly_step_ctrl`

## Requirements
- R1: The block accepts steps from -8 to +8 inclusive, each worth 250 ps nominal. `req_step` is a 5-bit two's-complement value.
- R2: A step of 0 drives `dly_zero`=1, `dly_lead`=0 and `dly_mag`=000.
- R3: A negative step drives `dly_lead`=1 and a positive step drives `dly_lead`=0. In both cases `dly_zero`=0.
- R4: For a non-zero step, `dly_mag` = |step|−1. Code 000 means one step and 111 means eight steps, in both directions.
- R5: Out of reset, `dly_dyn`=0, meaning the fixed power-up delay applies. It becomes 1 in the cycle after the first accepted request and never returns to 0.
- R6: On acceptance (valid and ready high at a rising edge), the new code appears after that edge. `syn_rst` is high for exactly `RST_CYCLES` cycles, starting in the same cycle as the new code.
- R7: `req_ready` is low from acceptance until the cycle after `syn_lock` is sampled high following reset release. With a lock that rises L cycles after release, ready is low for `RST_CYCLES`+L+1 cycles.
- R8: If lock is not seen within `LOCK_TIMEOUT` cycles of release, ready returns after exactly `RST_CYCLES`+`LOCK_TIMEOUT` busy cycles and `lock_fail` is set. `lock_fail` clears on the next accepted request.
- R9: An out-of-range step (below -8 or above +8) gives a one-cycle `req_err` pulse. It leaves the code outputs and `dly_dyn` unchanged, does not pulse `syn_rst`, and keeps ready high.
- R10: A request that is valid while ready is low leaves the outputs untouched. It is accepted unchanged at the first edge where ready is high again.
- R11: During and after reset, `req_ready`=1, `req_err`=0, `syn_rst`=0, `lock_fail`=0 and `dly_zero`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_step | input | STEP_W (5) | Signed delay request in steps |
| req_ready | output | 1 | Block idle and able to take a request |
| req_err | output | 1 | One-cycle pulse on a rejected request |
| dly_dyn | output | 1 | 1 = delay taken from this block's outputs |
| dly_zero | output | 1 | 1 = no delay |
| dly_lead | output | 1 | 1 = lead, 0 = lag |
| dly_mag | output | MAG_W (3) | Magnitude code, steps minus one |
| syn_rst | output | 1 | Reset to the clock synthesizer |
| syn_lock | input | 1 | Lock indication from the synthesizer |
| lock_fail | output | 1 | Sticky: last relock timed out |

## Verification
The bench sweeps every 5-bit step value, covering both range edges (±8 accepted, ±9 rejected) and the wrap to -16 and +15. A magnitude encoder that forgot the minus-one offset, or swapped the lead polarity, would miscode every non-zero step. The bench counts reset-high and busy cycles exactly, so an off-by-one in the hold counter or an early ready (one that does not wait for lock) shows up as a wrong count. It also drives a dead lock stub to hit the watchdog, and holds a request across a busy period. A design that queued the request, dropped it, or let it disturb the outputs mid-sequence would fail those checks.

// File: rtl/dly_pkg.sv
package dly_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_APPLY  = 2'd1,
        ST_RELOCK = 2'd2
    } dly_state_e;
endpackage

// File: rtl/dly_enc.sv
// Signed step -> zero flag / lead bit / magnitude-minus-one, plus range check.
module dly_enc #(
    parameter int STEP_W = 5,
    parameter int MAG_W  = 3
) (
    input  logic signed [STEP_W-1:0] step,
    output logic                     in_range,
    output logic                     zero,
    output logic                     lead,
    output logic [MAG_W-1:0]         mag
);
    localparam int MAX_STEPS = 1 << MAG_W;
    localparam logic signed [STEP_W-1:0] LIM_HI = STEP_W'(MAX_STEPS);
    localparam logic signed [STEP_W-1:0] LIM_LO = -LIM_HI;

    logic [STEP_W-1:0] abs_v;

    always_comb begin
        in_range = (step >= LIM_LO) && (step <= LIM_HI);
        abs_v    = step[STEP_W-1] ? STEP_W'(-step) : STEP_W'(step);
        zero     = (step == '0);
        lead     = !zero && step[STEP_W-1];
        mag      = zero ? '0 : MAG_W'(abs_v - STEP_W'(1));
    end
endmodule

// File: rtl/dly_cnt.sv
module dly_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (en)       q <= q + W'(1);
    end
endmodule

// File: rtl/dly_fsm.sv
module dly_fsm
    import dly_pkg::*;
#(
    parameter int RST_CYCLES   = 16,
    parameter int LOCK_TIMEOUT = 256,
    parameter int CNT_W        = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             range_ok,
    input  logic             syn_lock,
    input  logic [CNT_W-1:0] cnt,
    output logic             ready,
    output logic             load,
    output logic             cnt_clr,
    output logic             cnt_en,
    output logic             err,
    output logic             syn_rst,
    output logic             dyn,
    output logic             fail
);
    localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYCLES - 1);
    localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(LOCK_TIMEOUT - 1);

    dly_state_e st, nxt;
    logic       fail_set;

    always_comb begin
        nxt      = st;
        cnt_clr  = 1'b0;
        cnt_en   = 1'b0;
        fail_set = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req_valid && range_ok) begin       // accept
                    nxt     = ST_APPLY;
                    cnt_clr = 1'b1;
                end
            end
            ST_APPLY: begin
                if (cnt == RST_LAST) begin             // hold_done
                    nxt     = ST_RELOCK;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            ST_RELOCK: begin
                if (syn_lock) begin                    // locked
                    nxt = ST_IDLE;
                end else if (cnt == TO_LAST) begin     // timeout
                    nxt      = ST_IDLE;
                    fail_set = 1'b1;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign ready = (st == ST_IDLE);
    assign load  = ready && req_valid && range_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err     <= 1'b0;
            syn_rst <= 1'b0;
            dyn     <= 1'b0;
            fail    <= 1'b0;
        end else begin
            err     <= ready && req_valid && !range_ok;   // reject
            syn_rst <= (nxt == ST_APPLY);
            dyn     <= dyn | load;
            fail    <= load ? 1'b0 : (fail | fail_set);
        end
    end
endmodule

// File: rtl/dly_step_ctrl.sv
module dly_step_ctrl #(
    parameter int STEP_W       = 5,
    parameter int MAG_W        = 3,
    parameter int RST_CYCLES   = 16,
    parameter int LOCK_TIMEOUT = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic signed [STEP_W-1:0] req_step,
    output logic                     req_ready,
    output logic                     req_err,
    output logic                     dly_dyn,
    output logic                     dly_zero,
    output logic                     dly_lead,
    output logic [MAG_W-1:0]         dly_mag,
    output logic                     syn_rst,
    input  logic                     syn_lock,
    output logic                     lock_fail
);
    localparam int CNT_MAX = (RST_CYCLES > LOCK_TIMEOUT) ? RST_CYCLES : LOCK_TIMEOUT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             e_ok, e_zero, e_lead;
    logic [MAG_W-1:0] e_mag;
    logic             load, cnt_clr, cnt_en;
    logic [CNT_W-1:0] cnt;

    dly_enc #(.STEP_W(STEP_W), .MAG_W(MAG_W)) u_enc (
        .step(req_step), .in_range(e_ok), .zero(e_zero), .lead(e_lead), .mag(e_mag)
    );

    dly_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .q(cnt)
    );

    dly_fsm #(.RST_CYCLES(RST_CYCLES), .LOCK_TIMEOUT(LOCK_TIMEOUT), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .range_ok(e_ok),
        .syn_lock(syn_lock), .cnt(cnt), .ready(req_ready), .load(load),
        .cnt_clr(cnt_clr), .cnt_en(cnt_en), .err(req_err), .syn_rst(syn_rst),
        .dyn(dly_dyn), .fail(lock_fail)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_zero <= 1'b1;
            dly_lead <= 1'b0;
            dly_mag  <= '0;
        end else if (load) begin
            dly_zero <= e_zero;
            dly_lead <= e_lead;
            dly_mag  <= e_mag;
        end
    end
endmodule

// File: rtl/dly_step_ctrl_chk.sv
module dly_step_ctrl_chk #(
    parameter int STEP_W = 5,
    parameter int MAG_W  = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic signed [STEP_W-1:0] req_step,
    input logic                     req_ready,
    input logic                     req_err,
    input logic                     dly_dyn,
    input logic                     dly_zero,
    input logic                     dly_lead,
    input logic [MAG_W-1:0]         dly_mag,
    input logic                     syn_rst,
    input logic                     syn_lock,
    input logic                     lock_fail
);
    localparam logic signed [STEP_W-1:0] LIM = STEP_W'(1 << MAG_W);

    logic out_of_range;
    assign out_of_range = (req_step > LIM) || (req_step < -LIM);

    a_r2_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dly_zero |-> (!dly_lead && dly_mag == '0));

    a_r5_dyn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(dly_dyn));

    a_r6_rst_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        syn_rst |-> !req_ready);

    a_r7_ready_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> ($past(syn_lock) || lock_fail));

    a_r9_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && out_of_range) |=>
            (req_err && !syn_rst && $stable({dly_zero, dly_lead, dly_mag})));

    a_r10_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> $stable({dly_zero, dly_lead, dly_mag}));
endmodule

bind dly_step_ctrl dly_step_ctrl_chk #(.STEP_W(STEP_W), .MAG_W(MAG_W)) u_chk (.*);

// File: tb/dly_step_ctrl_tb.sv
`timescale 1ns/1ps
module dly_step_ctrl_tb;
    localparam int RSTC = 4;
    localparam int TOUT = 10;
    localparam int LAT  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic signed [4:0] req_step = '0;
    logic              req_ready, req_err, dly_dyn, dly_zero, dly_lead, syn_rst, lock_fail;
    logic [2:0]        dly_mag;
    logic              syn_lock;
    logic              stub_dead = 1'b0;
    int                lat_cnt;
    int                checks = 0;
    int                errors = 0;

    always #2.5 clk = ~clk;

    dly_step_ctrl #(.RST_CYCLES(RSTC), .LOCK_TIMEOUT(TOUT)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_step(req_step),
        .req_ready(req_ready), .req_err(req_err), .dly_dyn(dly_dyn),
        .dly_zero(dly_zero), .dly_lead(dly_lead), .dly_mag(dly_mag),
        .syn_rst(syn_rst), .syn_lock(syn_lock), .lock_fail(lock_fail)
    );

    // Behavioural synthesizer stub: lock drops in reset, rises LAT cycles after release.
    always_ff @(posedge clk) begin
        if (syn_rst || !rst_n) begin
            lat_cnt  <= 0;
            syn_lock <= 1'b0;
        end else if (!stub_dead && lat_cnt == LAT - 1) begin
            syn_lock <= 1'b1;
        end else if (!syn_lock) begin
            lat_cnt <= lat_cnt + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_mag(input int s);
        if (s == 0) return 0;
        return ((s < 0) ? -s : s) - 1;
    endfunction

    // Offer a request; returns at the negedge right after it was accepted.
    task automatic offer(input int s);
        @(negedge clk);
        req_valid = 1'b1;
        req_step  = 5'(s);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic count_busy(output int rst_n_cyc, output int busy);
        rst_n_cyc = 0;
        busy = 0;
        while (!req_ready && busy < 1000) begin
            if (syn_rst) rst_n_cyc++;
            busy++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int pz, pl, pm, pd;
        int nr, nb;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 ready", int'(req_ready), 1);
        chk("R11 err", int'(req_err), 0);
        chk("R11 syn_rst", int'(syn_rst), 0);
        chk("R11 lock_fail", int'(lock_fail), 0);
        chk("R11 zero", int'(dly_zero), 1);
        chk("R5 dyn at reset", int'(dly_dyn), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 dyn idle", int'(dly_dyn), 0);

        // R1 sweep of every 5-bit step
        for (int s = -16; s <= 15; s++) begin
            pz = dly_zero; pl = dly_lead; pm = dly_mag; pd = dly_dyn;
            offer(s);
            if (s >= -8 && s <= 8) begin
                chk($sformatf("R2 zero s=%0d", s), int'(dly_zero), (s == 0) ? 1 : 0);
                chk($sformatf("R3 lead s=%0d", s), int'(dly_lead), (s < 0) ? 1 : 0);
                chk($sformatf("R4 mag s=%0d", s), int'(dly_mag), exp_mag(s));
                chk($sformatf("R5 dyn s=%0d", s), int'(dly_dyn), 1);
                chk($sformatf("R1 accepted s=%0d", s), int'(req_ready), 0);
                chk($sformatf("R8 fail clear s=%0d", s), int'(lock_fail), 0);
                count_busy(nr, nb);
                chk($sformatf("R6 rst cycles s=%0d", s), nr, RSTC);
                chk($sformatf("R7 busy cycles s=%0d", s), nb, RSTC + LAT + 1);
                chk($sformatf("R7 lock at ready s=%0d", s), int'(syn_lock), 1);
            end else begin
                chk($sformatf("R9 err s=%0d", s), int'(req_err), 1);
                chk($sformatf("R9 ready s=%0d", s), int'(req_ready), 1);
                chk($sformatf("R9 no rst s=%0d", s), int'(syn_rst), 0);
                chk($sformatf("R9 code s=%0d", s),
                    int'({dly_zero, dly_lead, dly_mag}), (pz << 4) | (pl << 3) | pm);
                chk($sformatf("R9 dyn s=%0d", s), int'(dly_dyn), pd);
                @(negedge clk);
                chk($sformatf("R9 pulse s=%0d", s), int'(req_err), 0);
            end
        end

        // R10: request held while busy
        offer(-2);
        req_valid = 1'b1;
        req_step  = 5'(5);
        while (!req_ready) begin
            chk("R10 code held lead", int'(dly_lead), 1);
            chk("R10 code held mag", int'(dly_mag), 1);
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 taken lead", int'(dly_lead), 0);
        chk("R10 taken mag", int'(dly_mag), 4);
        chk("R10 taken busy", int'(req_ready), 0);
        count_busy(nr, nb);

        // R8: lock never returns
        stub_dead = 1'b1;
        offer(8);
        count_busy(nr, nb);
        chk("R8 timeout cycles", nb, RSTC + TOUT);
        chk("R8 lock_fail set", int'(lock_fail), 1);
        chk("R8 ready back", int'(req_ready), 1);
        stub_dead = 1'b0;
        offer(-8);
        chk("R8 lock_fail cleared", int'(lock_fail), 0);
        chk("R4 mag lead eight", int'(dly_mag), 7);
        count_busy(nr, nb);
        chk("R7 relock after fail", nb, RSTC + LAT + 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule